// File: doc/BRIEF.md
# Serial Fraction Alignment Shifter with Sticky Accumulation

This block aligns a floating-point fraction by moving it right one position per clock for a requested number of positions. Below the fraction it keeps three extension bits: guard, round and sticky. On every shift step the fraction's lowest bit moves into guard, guard moves into round, and round is offered to the sticky flip-flop. The sticky flip-flop remembers any 1 that reaches it, so it records whether any nonzero bit has been shifted out below round.

A load strobe captures a new fraction and shift count, clears all three extension bits and starts the shift sequence. A one-cycle done pulse marks the end of the sequence. A separate synchronous clear acts as a dominant reset on the sticky flip-flop only. Rounding, exponent arithmetic and single-cycle shifting belong to neighbouring logic.

Top module: `frac_align_shifter`

## Requirements
- R1: While `rst_n` is low, and after its release until the first load, `frac_o`, `guard_o`, `round_o`, `sticky_o` and `done_o` are all 0.
- R2: A clock edge with `load_i` high sets `frac_o` to `frac_i` and clears `guard_o`, `round_o` and `sticky_o`. This holds even if an earlier shift sequence is still running.
- R3: Each shift step moves the whole value right by one position. After the step, `frac_o` equals its old value shifted right with a 0 entering the MSB, `guard_o` equals the old `frac_o[0]`, and `round_o` equals the old `guard_o`.
- R4: On a shift step with `sticky_clr_i` low, the next `sticky_o` is the old `round_o` OR the old `sticky_o`. Once `sticky_o` is 1, it stays 1 until a load or a sticky clear.
- R5: A clock edge with `sticky_clr_i` high makes `sticky_o` 0, whatever the round bit and the current sticky value are.
- R6: A load with count N > 0 gives exactly N shift steps, on the N edges that follow the load edge. `done_o` is high for exactly the one cycle after the Nth step. A load with count 0 does no shift and raises `done_o` in the cycle right after the load edge.
- R7: When no shift sequence is running and `load_i` is low, `frac_o`, `guard_o` and `round_o` hold their values. `sticky_o` also holds, unless it is cleared.
- R8: Counts larger than FRAC_W+2 keep shifting. At the end of such a sequence `frac_o`, `guard_o` and `round_o` are 0, and `sticky_o` is 1 exactly when the loaded fraction was nonzero and no clear came after its last 1 entered the sticky position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture fraction and count, start a sequence |
| frac_i | input | FRAC_W | Fraction to align |
| amt_i | input | CNT_W | Number of right-shift steps |
| sticky_clr_i | input | 1 | Synchronous dominant clear of the sticky bit |
| frac_o | output | FRAC_W | Aligned fraction |
| guard_o | output | 1 | First extension bit below the fraction |
| round_o | output | 1 | Second extension bit below the fraction |
| sticky_o | output | 1 | OR-accumulation of everything shifted past round |
| done_o | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The bench builds the block with FRAC_W=8 and CNT_W=6. With these values the largest count, 63, is far beyond the 10 positions the fraction and extension bits span. This makes the over-long alignment case of R8 cheap to reach, and a full sequence fits in a few dozen cycles. The narrow fraction also lets hand-computed patterns check every bit. Random loads, reloads during a running sequence, and random sticky clears are all compared against a behavioural model on every clock.

// File: rtl/fas_pkg.sv
package fas_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } shift_op_e;

endpackage

// File: rtl/fas_sticky_cell.sv
module fas_sticky_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic din_i,
    output logic q_o
);

    typedef struct packed {
        logic q;
    } sticky_st_t;

    sticky_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.q = ~clr_i & (din_i | st_q.q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;

    AST_STICKY_KEEP:  assert property (@(posedge clk) disable iff (!rst_n) (q_o && !clr_i) |=> q_o);   // R4
    AST_STICKY_SET:   assert property (@(posedge clk) disable iff (!rst_n) (din_i && !clr_i) |=> q_o); // R4
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_i |=> !q_o);            // R5

endmodule

// File: rtl/fas_step_ctl.sv
module fas_step_ctl
    import fas_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] amt_i,
    output shift_op_e        op_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load_i) begin
            st_d.cnt  = amt_i;
            st_d.busy = (amt_i != '0);
            st_d.done = (amt_i == '0);
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
            if (st_q.cnt == CNT_ONE) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (load_i) begin
            op_o = OP_LOAD;
        end else if (st_q.busy) begin
            op_o = OP_SHIFT;
        end else begin
            op_o = OP_HOLD;
        end
    end

    assign done_o = st_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !load_i) |=> !done_o);                    // R6
    AST_ZERO_COUNT:  assert property (@(posedge clk) disable iff (!rst_n) (load_i && amt_i == '0) |=> (done_o && op_o != OP_SHIFT)); // R6
    AST_COUNT_DOWN:  assert property (@(posedge clk) disable iff (!rst_n) (op_o == OP_SHIFT) |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE)); // R6
    AST_DONE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (load_i || op_o == OP_HOLD));             // R6

endmodule

// File: rtl/fas_ext_path.sv
module fas_ext_path
    import fas_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shift_op_e         op_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic              guard_o,
    output logic              round_o
);

    localparam int MSB = FRAC_W - 1;

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic              guard;
        logic              round;
    } path_st_t;

    path_st_t          st_d, st_q;
    logic [FRAC_W-1:0] stepped;

    for (genvar i = 0; i < FRAC_W; i++) begin : g_step
        if (i == MSB) begin : g_top
            assign stepped[i] = 1'b0;
        end else begin : g_mid
            assign stepped[i] = st_q.frac[i+1];
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_LOAD: begin
                st_d.frac  = frac_i;
                st_d.guard = 1'b0;
                st_d.round = 1'b0;
            end
            OP_SHIFT: begin
                st_d.frac  = stepped;
                st_d.guard = st_q.frac[0];
                st_d.round = st_q.guard;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frac_o  = st_q.frac;
    assign guard_o = st_q.guard;
    assign round_o = st_q.round;

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (op_i == OP_SHIFT) |=>
        (frac_o == ($past(frac_o) >> 1) && guard_o == $past(frac_o[0]) && round_o == $past(guard_o)));          // R3
    AST_LOAD_TAKE:  assert property (@(posedge clk) disable iff (!rst_n) (op_i == OP_LOAD) |=>
        (frac_o == $past(frac_i) && !guard_o && !round_o));                                                        // R2
    AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (op_i == OP_HOLD) |=>
        ($stable(frac_o) && $stable(guard_o) && $stable(round_o)));                                                // R7

endmodule

// File: rtl/frac_align_shifter.sv
module frac_align_shifter
    import fas_pkg::*;
#(
    parameter int FRAC_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [CNT_W-1:0]  amt_i,
    input  logic              sticky_clr_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic              guard_o,
    output logic              round_o,
    output logic              sticky_o,
    output logic              done_o
);

    shift_op_e op_w;
    logic      stk_rst_w;
    logic      stk_in_w;

    fas_step_ctl #(
        .CNT_W (CNT_W)
    ) ctl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .amt_i  (amt_i),
        .op_o   (op_w),
        .done_o (done_o)
    );

    fas_ext_path #(
        .FRAC_W (FRAC_W)
    ) path_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_w),
        .frac_i  (frac_i),
        .frac_o  (frac_o),
        .guard_o (guard_o),
        .round_o (round_o)
    );

    assign stk_rst_w = sticky_clr_i | (op_w == OP_LOAD);
    assign stk_in_w  = (op_w == OP_SHIFT) & round_o;

    fas_sticky_cell stk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (stk_rst_w),
        .din_i (stk_in_w),
        .q_o   (sticky_o)
    );

    AST_LOAD_CLEARS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) load_i |=> !sticky_o);              // R2
    AST_STICKY_ACCUM:       assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == OP_SHIFT && !sticky_clr_i) |=> (sticky_o == ($past(round_o) | $past(sticky_o))));                  // R4
    AST_IDLE_STICKY:        assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == OP_HOLD && !sticky_clr_i) |=> $stable(sticky_o));                                                   // R7

endmodule

// File: tb/frac_align_shifter_tb.sv
module frac_align_shifter_tb_top;

    localparam int FW = 8;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [FW-1:0] frac_i = '0;
    logic [CW-1:0] amt_i = '0;
    logic          sticky_clr_i = 1'b0;
    logic [FW-1:0] frac_o;
    logic          guard_o, round_o, sticky_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    frac_align_shifter #(.FRAC_W(FW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .frac_i(frac_i), .amt_i(amt_i),
        .sticky_clr_i(sticky_clr_i), .frac_o(frac_o), .guard_o(guard_o),
        .round_o(round_o), .sticky_o(sticky_o), .done_o(done_o)
    );

    // behavioural reference: a wide word that the fraction and the two
    // plain extension bits live in, plus a flag and a remaining-step count
    logic [FW+1:0] m_word;
    bit            m_stk, m_done;
    int            m_left;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_word = '0; m_stk = 0; m_done = 0; m_left = 0;
        end else if (load_i) begin
            m_word = {frac_i, 2'b00};
            m_stk  = 0;
            m_left = int'(amt_i);
            m_done = (m_left == 0);
        end else begin
            m_done = 0;
            if (m_left > 0) begin
                m_stk  = m_stk | m_word[0];
                m_word = m_word >> 1;
                m_left = m_left - 1;
                m_done = (m_left == 0);
            end
            if (sticky_clr_i) m_stk = 0;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("R3 model fraction", frac_o, m_word[FW+1:2]);
            chk("R3 model guard/round", {guard_o, round_o}, m_word[1:0]);
            chk("R4 model sticky", sticky_o, m_stk);
            chk("R6 model done", done_o, m_done);
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        summary();
    end

    task automatic do_load(input logic [FW-1:0] f, input logic [CW-1:0] a);
        @(negedge clk);
        load_i = 1'b1; frac_i = f; amt_i = a;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 100 && !done_o; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset fraction", frac_o, 0);
        chk("R1 reset ext bits", {guard_o, round_o, sticky_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {frac_o, guard_o, round_o, sticky_o, done_o}, 0);

        // B5 = 1011_0101 shifted three times -> 0001_0110, g=1 r=0 s=1
        do_load(8'hB5, 6'd3);
        chk("R2 load value", frac_o, 8'hB5);
        repeat (3) @(negedge clk);
        chk("R3 three steps fraction", frac_o, 8'h16);
        chk("R3 three steps guard/round", {guard_o, round_o}, 2'b10);
        chk("R4 sticky caught bit", sticky_o, 1);
        chk("R6 done after third step", done_o, 1);
        @(negedge clk);
        chk("R6 done single cycle", done_o, 0);
        repeat (4) @(negedge clk);
        chk("R7 idle hold fraction", frac_o, 8'h16);
        chk("R7 idle hold ext", {guard_o, round_o, sticky_o}, 3'b101);

        // count zero
        do_load(8'h80, 6'd0);
        chk("R6 zero count done", done_o, 1);
        chk("R6 zero count no shift", frac_o, 8'h80);

        // reload during a running sequence
        do_load(8'hFF, 6'd20);
        repeat (9) @(negedge clk);
        chk("R4 sticky set mid-run", sticky_o, 1);
        do_load(8'h0F, 6'd2);
        chk("R2 reload fraction", frac_o, 8'h0F);
        chk("R2 reload clears ext", {guard_o, round_o, sticky_o}, 0);
        repeat (2) @(negedge clk);
        chk("R3 reload result", {frac_o, guard_o, round_o, sticky_o}, {8'h03, 3'b110});
        chk("R6 reload done", done_o, 1);

        // dominant sticky clear while ones still arrive
        do_load(8'hFF, 6'd20);
        repeat (5) @(negedge clk);
        sticky_clr_i = 1'b1;
        chk("R5 round high before clear", round_o, 1);
        @(negedge clk);
        sticky_clr_i = 1'b0;
        chk("R5 clear dominates", sticky_o, 0);
        wait_done();
        chk("R8 long run sticky", sticky_o, 1);

        // late clear after all ones are gone
        do_load(8'hFF, 6'd20);
        repeat (11) @(negedge clk);
        sticky_clr_i = 1'b1;
        @(negedge clk);
        sticky_clr_i = 1'b0;
        wait_done();
        chk("R5 late clear kept", sticky_o, 0);
        chk("R8 everything flushed", {frac_o, guard_o, round_o}, 0);

        // maximum count
        do_load(8'h01, 6'd63);
        repeat (63) @(negedge clk);
        chk("R8 max count done", done_o, 1);
        chk("R8 max count result", {frac_o, guard_o, round_o, sticky_o}, 11'h001);

        // random traffic, checked by the model every clock
        for (int n = 0; n < 60; n++) begin
            do_load(FW'($urandom), CW'($urandom_range(0, 14)));
            for (int c = 0; c < 16 && !done_o; c++) begin
                sticky_clr_i = ($urandom_range(0, 7) == 0);
                @(negedge clk);
            end
            sticky_clr_i = 1'b0;
            if ($urandom_range(0, 3) != 0) wait_done();
        end
        repeat (3) @(negedge clk);
        summary();
    end

endmodule